// File: doc/BRIEF.md
# Integrating Receive Noise Filter

This block cleans a single-bit serial receive line before a protocol decoder sees it. The raw line is first brought into the filter clock domain through a chain of flip-flops. A sampler register then captures it on each rising clock edge. On the following falling edge, a saturating up/down counter moves one step toward the sampled level.

The cleaned output is a held bit with hysteresis. It goes high only when the counter reaches its top value, and it goes low only when the counter reaches zero. In between, the output keeps its last value. A short burst of noise therefore moves the counter partway and is then undone, and the output does not change. A real level change has to last long enough to carry the counter across its whole range.

The counter width and the reset level are parameters. The default is a 4-bit counter that resets to the idle-high state. With the defaults, a clean edge on the line appears at the output exactly 17 rising edges after the first rising edge that sees it.

Top module: `rx_glitch_filter`

## Requirements
- R1: While reset is high at a rising edge, and afterwards until the input changes, `rx_clean` equals the parameter `RST_HIGH` (default 1). With the default, the counter is held at its top value 2^CNT_W-1.
- R2: The input passes two synchronizer stages and one sampler stage. For a level first present at `rx_raw` at rising edge k, the first counter step using that level happens on the falling edge after rising edge k+2. With defaults, from a saturated counter the output changes at rising edge k+17 and not before.
- R3: On each falling edge, the counter rises by one when the sample is 1 and falls by one when the sample is 0, unless it is at an end value.
- R4: At the top value 2^CNT_W-1 (15 by default), a sample of 1 leaves the counter unchanged. It never wraps to 0.
- R5: At 0, a sample of 0 leaves the counter unchanged. It never wraps to the top value.
- R6: If the counter holds the top value at a rising edge, `rx_clean` is 1 after that edge.
- R7: If the counter holds 0 at a rising edge, `rx_clean` is 0 after that edge.
- R8: If the counter holds a value strictly between 0 and the top value at a rising edge, `rx_clean` keeps its value across that edge. As a result, a run of 14 or fewer opposite samples starting from a saturated counter never changes the output.
- R9: A one-cycle pulse of the opposite level on `rx_raw` never changes `rx_clean`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock. Sampling and output use the rising edge; the counter uses the falling edge. |
| rst | input | 1 | Synchronous reset, active high |
| rx_raw | input | 1 | Raw receive line, asynchronous to `clk` |
| rx_clean | output | 1 | Filtered receive level, registered |

## Verification
On every cycle, the assertions check the counter's local behaviour: single steps in the direction of the sample, no wrap at either end, and the output being set, cleared or held according to the counter value at each rising edge. The counter is not visible at the ports. The exact end-to-end latency, the rejection of single-cycle glitches and the threshold between 14 and 15 opposite samples can therefore only be shown by the bench. It drives run-length sweeps and long pseudo-random sequences and compares the output on every cycle with an arithmetic model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Action the output register takes at a rising edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } rxf_act_e;

  // Top end value of an n-bit counter
  function automatic int unsigned rxf_top(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_HIGH;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_HIGH;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/rxf_sampler.sv
module rxf_sampler #(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_sync,
  output logic smp
);

  always_ff @(posedge clk) begin
    if (rst) smp <= RST_HIGH;
    else     smp <= d_sync;
  end

endmodule

// File: rtl/rxf_integrator.sv
module rxf_integrator #(
  parameter int unsigned CNT_W    = 4,
  parameter bit          RST_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp,
  output logic [CNT_W-1:0] cnt
);
  import rxf_pkg::*;

  localparam logic [CNT_W-1:0] TOP  = CNT_W'(rxf_top(CNT_W));
  localparam logic [CNT_W-1:0] BOT  = '0;
  localparam logic [CNT_W-1:0] INIT = RST_HIGH ? TOP : BOT;

  // Counter moves on the falling edge, using the sample from the rising edge before it
  always_ff @(negedge clk) begin
    if (rst)                      cnt <= INIT;
    else if (smp  && cnt != TOP)  cnt <= cnt + 1'b1;
    else if (!smp && cnt != BOT)  cnt <= cnt - 1'b1;
  end

  // R3
  step_up_chk: assert property (@(negedge clk) disable iff (rst)
    (smp && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
  // R3
  step_dn_chk: assert property (@(negedge clk) disable iff (rst)
    (!smp && cnt != BOT) |=> (cnt == $past(cnt) - 1'b1));
  // R4
  no_overflow_chk: assert property (@(negedge clk) disable iff (rst)
    (smp && cnt == TOP) |=> (cnt == TOP));
  // R5
  no_underflow_chk: assert property (@(negedge clk) disable iff (rst)
    (!smp && cnt == BOT) |=> (cnt == BOT));

endmodule

// File: rtl/rxf_hyst_latch.sv
module rxf_hyst_latch #(
  parameter int unsigned CNT_W    = 4,
  parameter bit          RST_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  output logic             q
);
  import rxf_pkg::*;

  localparam logic [CNT_W-1:0] TOP = CNT_W'(rxf_top(CNT_W));

  rxf_act_e act;

  always_comb begin
    if (cnt == TOP)      act = ACT_SET;
    else if (cnt == '0)  act = ACT_CLR;
    else                 act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_HIGH;
    else begin
      case (act)
        ACT_SET: q <= 1'b1;
        ACT_CLR: q <= 1'b0;
        default: q <= q;
      endcase
    end
  end

  // R6
  set_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> q);
  // R7
  clr_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !q);
  // R8
  hold_band_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != TOP && cnt != '0) |=> $stable(q));

endmodule

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter #(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RST_HIGH    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_raw,
  output logic rx_clean
);

  logic             rx_sync;
  logic             rx_smp;
  logic [CNT_W-1:0] level_cnt;

  rxf_sync #(.STAGES(SYNC_STAGES), .RST_HIGH(RST_HIGH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (rx_raw),
    .q_sync  (rx_sync)
  );

  rxf_sampler #(.RST_HIGH(RST_HIGH)) u_smp (
    .clk    (clk),
    .rst    (rst),
    .d_sync (rx_sync),
    .smp    (rx_smp)
  );

  rxf_integrator #(.CNT_W(CNT_W), .RST_HIGH(RST_HIGH)) u_int (
    .clk (clk),
    .rst (rst),
    .smp (rx_smp),
    .cnt (level_cnt)
  );

  rxf_hyst_latch #(.CNT_W(CNT_W), .RST_HIGH(RST_HIGH)) u_lat (
    .clk (clk),
    .rst (rst),
    .cnt (level_cnt),
    .q   (rx_clean)
  );

  // R1
  reset_level_chk: assert property (@(posedge clk)
    rst |=> (rx_clean == RST_HIGH));

endmodule

// File: tb/tb_rx_glitch_filter.sv
module tb_rx_glitch_filter;

  localparam int TOP = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_raw = 1'b1;
  logic rx_clean;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state
  int m_cnt;
  bit m_s1, m_s2, m_smp, m_q;

  always #4 clk = ~clk;

  rx_glitch_filter dut (
    .clk      (clk),
    .rst      (rst),
    .rx_raw   (rx_raw),
    .rx_clean (rx_clean)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: drive input, pass a rising edge, compare, pass a falling edge
  task automatic step(input logic v, input string tag);
    rx_raw = v;
    @(posedge clk);
    if (m_cnt == TOP)   m_q = 1'b1;
    else if (m_cnt == 0) m_q = 1'b0;
    m_smp = m_s2;
    m_s2  = m_s1;
    m_s1  = v;
    #1;
    check(tag, rx_clean, m_q);
    @(negedge clk);
    if (m_smp && m_cnt < TOP)      m_cnt++;
    else if (!m_smp && m_cnt > 0)  m_cnt--;
    #1;
  endtask

  task automatic run(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) step(v, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_raw = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    rst = 1'b0;
    m_cnt = TOP; m_s1 = 1; m_s2 = 1; m_smp = 1; m_q = 1;
  endtask

  initial begin
    logic [15:0] lfsr;
    int first_low;
    int fall_at;

    do_reset();
    // R1: reset level visible at output
    check("R1", rx_clean, 1'b1);
    run(1'b1, 5, "R1");

    // R9: single-cycle low glitches on an idle-high line
    for (int k = 0; k < 6; k++) begin
      step(1'b0, "R9");
      run(1'b1, 7, "R9");
    end

    // R8/R7/R4: run-length sweep of low pulses from saturated high
    for (int len = 1; len <= 20; len++) begin
      run(1'b0, len, (len < 15) ? "R8" : "R7");
      run(1'b1, 40, (len < 15) ? "R4" : "R6");
    end

    // R2: exact latency of a clean falling edge
    first_low = -1; fall_at = -1;
    for (int i = 0; i < 30; i++) begin
      step(1'b0, "R2");
      if (first_low < 0) first_low = i;
      if (fall_at < 0 && rx_clean == 1'b0) fall_at = i;
    end
    checks++;
    if (fall_at - first_low != 17) begin
      errors++;
      $display("FAIL R2 latency got %0d exp %0d", fall_at - first_low, 17);
    end

    // R5/R8/R6: run-length sweep of high pulses from saturated low
    run(1'b0, 10, "R5");
    for (int len = 1; len <= 20; len++) begin
      run(1'b1, len, (len < 15) ? "R8" : "R6");
      run(1'b0, 40, (len < 15) ? "R5" : "R7");
    end
    // R9: single-cycle high glitches on a low line
    for (int k = 0; k < 6; k++) begin
      step(1'b1, "R9");
      run(1'b0, 7, "R9");
    end

    // R3: pseudo-random bursts with a biased level, compared every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic bias;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bias = (i / 400) % 2 == 1;
      step((lfsr[2:0] == 3'b000) ? ~bias : bias, "R3");
    end

    // R1: reset from a low state restores the idle level
    run(1'b0, 40, "R7");
    do_reset();
    check("R1", rx_clean, 1'b1);
    run(1'b1, 4, "R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule